// File: doc/BRIEF.md
# LIN Bus Activity and Bit-Time Monitor

This block listens to the receive line of a LIN node. It does two jobs. It keeps a bus-activity flag that tells software when it is safe to retune the local oscillator. It also measures the length of one LIN bit in module clock cycles, taken from the 0x55 sync field at the start of every header. Software compares the measured count with the ideal count for its baud rate and decides how to trim.

The activity flag is deliberately pessimistic. It rises on any falling edge that survives the receive filter, including a noise spike. It drops only when the surrounding logic reports that a frame finished cleanly, so an errored or truncated frame leaves it high until the next good frame. Software can also mark the current frame as one it does not care about. That opens a trim window that lasts until the frame ends, whatever the flag says.

The default counter width covers 8 bit times at 1 kbit/s with a 6 MHz module clock. This is the slowest case across the 2 MHz to 6 MHz clock range that the block must tolerate.

Top module: `lin_activity_monitor`

## Requirements
- R1: The RX line passes through two synchronizing flops. The filtered level changes only after the synchronized input has differed from it on FILT_LEN (default 4) consecutive clocks. Shorter pulses have no effect at the outputs.
- R2: Every accepted falling edge, noise included, makes `bus_active` high on the following clock.
- R3: `bus_active` goes low only on the clock after a `frame_done` pulse. A `frame_abort` pulse or any length of idle bus leaves it high. If an accepted falling edge and `frame_done` fall in the same cycle, the flag stays high.
- R4: Header tracking runs in this order. The break is the first accepted falling edge after reset or after a `frame_done`/`frame_abort` pulse. The next accepted rising edge ends the break. The next accepted falling edge starts sync timing. The fourth accepted falling edge after that ends sync timing. A frame boundary pulse returns tracking to waiting for a break.
- R5: Let N be the number of clocks between the accepted falling edge that starts sync timing and the one that ends it. The measurement is then (N + 4) >> 3, which is N divided by 8 and rounded half up.
- R6: `bit_cycles` takes a new measurement together with a one-cycle `bit_cycles_vld` pulse. At all other times it holds its value.
- R7: Sync timing is abandoned if N reaches 2^CNT_W - 1 before the ending edge arrives. In that case there is no update and no valid pulse, and further edges are ignored until a frame boundary pulse. The default CNT_W is 16.
- R8: An `ignore_msg` pulse holds `trim_ok` high from the next clock until a `frame_done` or `frame_abort` pulse closes the window. A frame boundary pulse in the same cycle as `ignore_msg` wins, and no window opens.
- R9: `trim_ok` is high exactly when `bus_active` is low or an ignore window is open.
- R10: After reset, `bus_active` is 0, `bit_cycles` is 0, `bit_cycles_vld` is 0 and `trim_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_raw | input | 1 | Unsynchronized LIN receive line, high when recessive |
| frame_done | input | 1 | One-cycle pulse: a frame completed normally |
| frame_abort | input | 1 | One-cycle pulse: a frame ended with an error |
| ignore_msg | input | 1 | One-cycle pulse: software does not care about the current frame |
| bus_active | output | 1 | Bus-activity flag |
| bit_cycles | output | CNT_W-2 | Measured clocks per LIN bit |
| bit_cycles_vld | output | 1 | One-cycle strobe when `bit_cycles` updates |
| trim_ok | output | 1 | Oscillator may be trimmed now |

## Verification
A stale activity flag shows up as a wrong `trim_ok` on the clock after the edge or the boundary pulse that should have moved it. The reference model therefore catches it within one cycle. A filter that is too short or too long shifts every accepted edge: glitches then set the flag, or edges arrive late. A header tracker that lost its place shows up as a missing or extra `bit_cycles_vld` strobe, or a wrong count, within one sync field. A failed overflow abort appears as a spurious update after the long gap.

// File: rtl/lam_pkg.sv
package lam_pkg;

  typedef enum logic [2:0] {
    HDR_IDLE,
    HDR_BREAK,
    HDR_DELIM,
    HDR_TIMING,
    HDR_WAIT
  } hdr_state_e;

  // Eight bit times span the timed part of the sync field; round half up.
  localparam int unsigned SPAN_SHIFT = 3;

  function automatic int unsigned lam_bit_time(input int unsigned span);
    return (span + (1 << (SPAN_SHIFT - 1))) >> SPAN_SHIFT;
  endfunction

endpackage

// File: rtl/lam_rx_filter.sv
module lam_rx_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_raw,
  output logic flt_level,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int RUN_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

  logic sync1_q, sync2_q;
  logic [RUN_W-1:0] run_q;
  logic differs, flip;

  assign differs  = sync2_q ^ flt_level;
  assign flip     = differs && (run_q == RUN_LAST);
  assign fall_evt = flip && !sync2_q;
  assign rise_evt = flip && sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= 1'b1;
      sync2_q   <= 1'b1;
      flt_level <= 1'b1;
      run_q     <= '0;
    end else begin
      sync1_q <= rx_raw;
      sync2_q <= sync1_q;
      if (!differs || flip) run_q <= '0;
      else                  run_q <= run_q + 1'b1;
      if (flip) flt_level <= sync2_q;
    end
  end
endmodule

// File: rtl/lam_header_timer.sv
module lam_header_timer
  import lam_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BT_W  = CNT_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fall_evt,
  input  logic            rise_evt,
  input  logic            frame_end,
  output logic [BT_W-1:0] bit_cycles,
  output logic            bit_vld,
  output logic            ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [1:0]       LAST_GAP = 2'd3;

  hdr_state_e       state_q;
  logic [CNT_W-1:0] span_q;
  logic [1:0]       gaps_q;
  logic             end_edge;
  logic [BT_W-1:0]  bt_next;

  assign end_edge = (state_q == HDR_TIMING) && fall_evt && (gaps_q == LAST_GAP);
  assign ovf_evt  = (state_q == HDR_TIMING) && !frame_end && !end_edge && (span_q == CNT_MAX);
  assign bt_next  = BT_W'(lam_bit_time(32'(span_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= HDR_IDLE;
      span_q     <= '0;
      gaps_q     <= '0;
      bit_cycles <= '0;
      bit_vld    <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (frame_end) begin
        state_q <= HDR_IDLE;
      end else begin
        unique case (state_q)
          HDR_IDLE:  if (fall_evt) state_q <= HDR_BREAK;
          HDR_BREAK: if (rise_evt) state_q <= HDR_DELIM;
          HDR_DELIM: if (fall_evt) begin
            state_q <= HDR_TIMING;
            span_q  <= CNT_W'(1);
            gaps_q  <= '0;
          end
          HDR_TIMING: begin
            if (end_edge) begin
              bit_cycles <= bt_next;
              bit_vld    <= 1'b1;
              state_q    <= HDR_WAIT;
            end else if (span_q == CNT_MAX) begin
              state_q <= HDR_WAIT;
            end else begin
              span_q <= span_q + 1'b1;
              if (fall_evt) gaps_q <= gaps_q + 1'b1;
            end
          end
          default: state_q <= HDR_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/lam_activity.sv
module lam_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_evt,
  input  logic frame_done,
  input  logic frame_abort,
  input  logic ignore_msg,
  output logic bus_active,
  output logic ign_open,
  output logic trim_ok
);
  logic frame_end;
  assign frame_end = frame_done || frame_abort;
  assign trim_ok   = !bus_active || ign_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_active <= 1'b0;
      ign_open   <= 1'b0;
    end else begin
      if (fall_evt)        bus_active <= 1'b1;
      else if (frame_done) bus_active <= 1'b0;
      if (frame_end)       ign_open <= 1'b0;
      else if (ignore_msg) ign_open <= 1'b1;
    end
  end
endmodule

// File: rtl/lin_activity_monitor.sv
module lin_activity_monitor #(
  parameter int  CNT_W    = 16,
  parameter int  FILT_LEN = 4,
  localparam int BT_W     = CNT_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_raw,
  input  logic            frame_done,
  input  logic            frame_abort,
  input  logic            ignore_msg,
  output logic            bus_active,
  output logic [BT_W-1:0] bit_cycles,
  output logic            bit_cycles_vld,
  output logic            trim_ok
);
  logic flt_level, fall_evt, rise_evt, ovf_evt, ign_open, frame_end;

  assign frame_end = frame_done || frame_abort;

  lam_rx_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw),
    .flt_level(flt_level), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  lam_header_timer #(.CNT_W(CNT_W), .BT_W(BT_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .rise_evt(rise_evt),
    .frame_end(frame_end), .bit_cycles(bit_cycles), .bit_vld(bit_cycles_vld),
    .ovf_evt(ovf_evt)
  );

  lam_activity u_act (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .frame_done(frame_done),
    .frame_abort(frame_abort), .ignore_msg(ignore_msg),
    .bus_active(bus_active), .ign_open(ign_open), .trim_ok(trim_ok)
  );
endmodule

// File: rtl/lam_checker.sv
module lam_checker #(
  parameter int BT_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flt_level,
  input logic            fall_evt,
  input logic            ovf_evt,
  input logic            frame_done,
  input logic            frame_abort,
  input logic            ignore_msg,
  input logic            bus_active,
  input logic [BT_W-1:0] bit_cycles,
  input logic            bit_cycles_vld,
  input logic            trim_ok
);
  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !flt_level);                                                  // R1
  AST_SET_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> bus_active);                                                  // R2
  AST_CLEAR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_active) |-> $past(frame_done));                                  // R3
  AST_ABORT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && frame_abort && !frame_done) |=> bus_active);                // R3
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cycles_vld |=> !bit_cycles_vld);                                       // R6
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_cycles_vld |-> $stable(bit_cycles));                                  // R6
  AST_NO_OVERFLOW_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !bit_cycles_vld);                                              // R7
  AST_IGNORE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_msg && !frame_done && !frame_abort) |=> trim_ok);                  // R8
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && frame_abort && !frame_done && !fall_evt) |=> !trim_ok);     // R8
  AST_IDLE_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> trim_ok);                                                  // R9
endmodule

bind lin_activity_monitor lam_checker #(.BT_W(BT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_level(flt_level), .fall_evt(fall_evt),
  .ovf_evt(ovf_evt), .frame_done(frame_done), .frame_abort(frame_abort),
  .ignore_msg(ignore_msg), .bus_active(bus_active), .bit_cycles(bit_cycles),
  .bit_cycles_vld(bit_cycles_vld), .trim_ok(trim_ok)
);

// File: tb/sim_lin_activity_monitor.sv
`timescale 1ns/1ps
module sim_lin_activity_monitor;
  localparam int CNT_W = 10;
  localparam int BT_W  = CNT_W - 2;
  localparam int SPAN_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_raw = 1'b1, frame_done = 1'b0, frame_abort = 1'b0, ignore_msg = 1'b0;
  logic bus_active, bit_cycles_vld, trim_ok;
  logic [BT_W-1:0] bit_cycles;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lin_activity_monitor #(.CNT_W(CNT_W), .FILT_LEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .frame_done(frame_done),
    .frame_abort(frame_abort), .ignore_msg(ignore_msg), .bus_active(bus_active),
    .bit_cycles(bit_cycles), .bit_cycles_vld(bit_cycles_vld), .trim_ok(trim_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1, m_s2, m_lvl, m_act, m_ign, m_bt, m_vld, m_hs, m_span, m_falls;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_lvl = 1; m_act = 0; m_ign = 0; m_bt = 0; m_vld = 0;
      m_hs = 0; m_span = 0; m_falls = 0; hist.delete();
    end else begin
      int fall, rise, all_diff;
      fall = 0; rise = 0;
      hist.push_back(m_s2[0]);
      if (hist.size() > 4) void'(hist.pop_front());
      all_diff = (hist.size() == 4);
      foreach (hist[i]) if (int'(hist[i]) == m_lvl) all_diff = 0;
      if (all_diff) begin
        if (m_lvl == 1) fall = 1; else rise = 1;
        m_lvl = m_s2;
      end
      m_s2 = m_s1; m_s1 = rx_raw;
      m_vld = 0;
      if (fall) m_act = 1; else if (frame_done) m_act = 0;
      if (frame_done || frame_abort) m_ign = 0; else if (ignore_msg) m_ign = 1;
      if (frame_done || frame_abort) m_hs = 0;
      else case (m_hs)
        0: if (fall) m_hs = 1;
        1: if (rise) m_hs = 2;
        2: if (fall) begin m_hs = 3; m_span = 1; m_falls = 0; end
        3: if (fall && m_falls == 3) begin
             m_bt = (m_span + 4) / 8; m_vld = 1; m_hs = 4;
           end else begin
             if (fall) m_falls++;
             if (m_span == SPAN_MAX) m_hs = 4; else m_span++;
           end
        default: ;
      endcase
    end
  end

  // per-cycle comparison and strobe monitor
  int vld_seen = 0, last_bt = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_active == m_act[0], "R2/R3 model bus_active", int'(bus_active), m_act);
      chk(trim_ok == (!m_act[0] || m_ign[0]), "R8/R9 model trim_ok", int'(trim_ok),
          int'(!m_act[0] || m_ign[0]));
      chk(int'(bit_cycles) == m_bt, "R5 model bit_cycles", int'(bit_cycles), m_bt);
      chk(bit_cycles_vld == m_vld[0], "R6 model vld", int'(bit_cycles_vld), m_vld);
      if (bit_cycles_vld) begin vld_seen++; last_bt = int'(bit_cycles); end
    end
  end

  // ---------------- stimulus ----------------
  task automatic hold(input logic v, input int n);
    rx_raw = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) frame_done = 1'b1;
    else if (which == 1) frame_abort = 1'b1;
    else if (which == 2) ignore_msg = 1'b1;
    else begin ignore_msg = 1'b1; frame_abort = 1'b1; end
    @(negedge clk);
    frame_done = 1'b0; frame_abort = 1'b0; ignore_msg = 1'b0;
  endtask

  task automatic send_header(input int p, input int extra);
    hold(1'b0, 13 * p);
    hold(1'b1, p);
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(((8'h55 >> i) & 1) != 0, p + ((i == 6) ? extra : 0));
    hold(1'b1, 2 * p);
  endtask

  initial begin
    int v0;
    repeat (5) @(negedge clk);
    chk(bus_active == 1'b0, "R10 reset bus_active", int'(bus_active), 0);
    chk(bit_cycles == '0, "R10 reset bit_cycles", int'(bit_cycles), 0);
    chk(bit_cycles_vld == 1'b0, "R10 reset vld", int'(bit_cycles_vld), 0);
    chk(trim_ok == 1'b1, "R10 reset trim_ok", int'(trim_ok), 1);
    rst_n = 1'b1;
    hold(1'b1, 5);

    hold(1'b0, 3); hold(1'b1, 12);
    chk(bus_active == 1'b0, "R1 short glitch ignored", int'(bus_active), 0);

    hold(1'b0, 5); hold(1'b1, 12);
    chk(bus_active == 1'b1, "R2 noise edge sets flag", int'(bus_active), 1);
    chk(trim_ok == 1'b0, "R9 trim closed while active", int'(trim_ok), 0);
    pulse(1); hold(1'b1, 20);
    chk(bus_active == 1'b1, "R3 abort keeps flag", int'(bus_active), 1);

    v0 = vld_seen;
    send_header(20, 0);
    chk(vld_seen == v0 + 1, "R4 one update per header", vld_seen, v0 + 1);
    chk(last_bt == 20, "R5 bit time 20", last_bt, 20);
    chk(int'(bit_cycles) == 20, "R6 count held", int'(bit_cycles), 20);
    pulse(0); hold(1'b1, 3);
    chk(bus_active == 1'b0, "R3 done clears flag", int'(bus_active), 0);
    chk(trim_ok == 1'b1, "R9 trim open when idle", int'(trim_ok), 1);

    send_header(10, 3); pulse(0);
    chk(last_bt == 10, "R5 round down at +3", last_bt, 10);
    send_header(10, 4); pulse(0);
    chk(last_bt == 11, "R5 round up at +4", last_bt, 11);

    send_header(12, 0);
    chk(last_bt == 12, "R5 bit time 12", last_bt, 12);
    pulse(2); hold(1'b1, 30);
    chk(trim_ok == 1'b1, "R8 ignore opens window", int'(trim_ok), 1);
    pulse(1); hold(1'b1, 2);
    chk(trim_ok == 1'b0, "R8 abort closes window", int'(trim_ok), 0);
    chk(bus_active == 1'b1, "R3 flag after errored frame", int'(bus_active), 1);
    pulse(3); hold(1'b1, 2);
    chk(trim_ok == 1'b0, "R8 end beats ignore", int'(trim_ok), 0);

    v0 = vld_seen;
    hold(1'b0, 100); hold(1'b1, 20); hold(1'b0, 10);
    hold(1'b1, SPAN_MAX + 200);
    hold(1'b0, 10); hold(1'b1, 10); hold(1'b0, 10); hold(1'b1, 10);
    hold(1'b0, 10); hold(1'b1, 10); hold(1'b0, 10); hold(1'b1, 20);
    chk(vld_seen == v0, "R7 overflow no update", vld_seen, v0);
    chk(int'(bit_cycles) == 12, "R7 count kept", int'(bit_cycles), 12);
    pulse(1);
    send_header(15, 0); pulse(0);
    chk(last_bt == 15, "R4 tracking resumes after boundary", last_bt, 15);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule